// File: doc/BRIEF.md
# Coded-Ratio Flash Clock Divider

This block derives the serial-flash interface clock from a fast reference clock (nominally 800 MHz). Software writes one 8-bit control word that carries a run bit, a 4-bit ratio code and an interrupt-enable bit. The ratio code selects one of fourteen even divide ratios between 4 and 128, so the output runs between 200 MHz and 6.25 MHz. At initialisation software selects code 9 (divide by 32, 25 MHz).

The output has a 50% duty cycle and is held low whenever the run bit is clear. The intended way to change the ratio is to clear the run bit first and then write the new code with the run and interrupt-enable bits set. A code written while the clock is running is still safe. The running ratio is replaced only at the moment the output falls, so a high phase is never cut short. Codes 14 and 15 are reserved. Writing one of them keeps the previous ratio, while the other bits of the same write still take effect.

Top module: `flash_clk_divider`

## Requirements
- R1: After reset the control word reads 0x12: run bit 0, code 9, interrupt enable 0. The divided clock and the interrupt-enable output are both low.
- R2: A read returns the control word in this layout: bit 0 is the run bit, bits 4:1 are the ratio code, bit 6 is the interrupt enable, and all other bits are zero.
- R3: Codes 0 to 13 select the ratios 4, 6, 8, 10, 12, 16, 18, 20, 24, 32, 40, 50, 64 and 128, in that order. While running, the output stays high for ratio/2 reference cycles and then low for ratio/2 reference cycles.
- R4: The divided clock is low one cycle after the run bit is cleared, and it stays low while the run bit is clear.
- R5: After a write sets the run bit from the stopped state, the output first rises ratio/2+1 cycles after the clock edge that performs the write.
- R6: A code written while the output is high does not shorten that high phase. The new ratio takes effect from the next falling edge of the output, so the low phase that follows already uses it.
- R7: A write carrying code 14 or 15 leaves the stored code and the running ratio unchanged.
- R8: The interrupt-enable output follows bit 6 of the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word to write |
| rd_data | output | 8 | Current control word |
| clk_out | output | 1 | Divided, gated clock |
| irq_en | output | 1 | Interrupt enable from the control word |

## Verification
The hardest case to reach is a ratio change while the clock is running and partway through a high phase. Software normally stops the clock before changing the ratio, so this case does not come up in the usual sequence. The bench waits until it sees the output high at a falling reference edge and writes a much smaller ratio at that point. It then measures that the high phase still lasts the old half-period and that the low phase that follows uses the new one. Random codes, reserved codes included, are mixed with stop-and-start sequences to check the start-up latency and the phase lengths for every ratio.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int REG_W     = 8;
  localparam int CODE_W    = 4;
  localparam int NUM_CODES = 14;
  localparam int MAX_RATIO = 128;
  localparam int RST_CODE  = 9;
  localparam int RUN_BIT   = 0;
  localparam int CODE_LSB  = 1;
  localparam int IRQ_BIT   = 6;

  // Divide ratio for each code; the reserved codes map to the slowest ratio.
  function automatic logic [7:0] ratio_of(input logic [CODE_W-1:0] c);
    logic [7:0] r;
    case (c)
      4'd0:    r = 8'd4;
      4'd1:    r = 8'd6;
      4'd2:    r = 8'd8;
      4'd3:    r = 8'd10;
      4'd4:    r = 8'd12;
      4'd5:    r = 8'd16;
      4'd6:    r = 8'd18;
      4'd7:    r = 8'd20;
      4'd8:    r = 8'd24;
      4'd9:    r = 8'd32;
      4'd10:   r = 8'd40;
      4'd11:   r = 8'd50;
      4'd12:   r = 8'd64;
      default: r = 8'd128;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fcd_rst_sync.sv
module fcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/fcd_ctrl_reg.sv
module fcd_ctrl_reg
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic              run_o,
  output logic [CODE_W-1:0] code_o,
  output logic              irq_o,
  output logic [REG_W-1:0]  rd_data_o
);
  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_CODES - 1);
  localparam logic [CODE_W-1:0] INIT_CODE = CODE_W'(RST_CODE);

  logic              run_q, run_d;
  logic              irq_q, irq_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] wr_code;

  assign wr_code = wr_data[CODE_LSB +: CODE_W];

  always_comb begin
    run_d  = run_q;
    irq_d  = irq_q;
    code_d = code_q;
    if (wr_en) begin
      run_d = wr_data[RUN_BIT];
      irq_d = wr_data[IRQ_BIT];
      if (wr_code <= LAST_CODE) code_d = wr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
      code_q <= INIT_CODE;
    end else begin
      run_q  <= run_d;
      irq_q  <= irq_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    rd_data_o                      = '0;
    rd_data_o[RUN_BIT]             = run_q;
    rd_data_o[CODE_LSB +: CODE_W]  = code_q;
    rd_data_o[IRQ_BIT]             = irq_q;
  end

  assign run_o  = run_q;
  assign code_o = code_q;
  assign irq_o  = irq_q;

  // R7: reserved codes leave the stored code alone
  a_r7_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_code > LAST_CODE) |=> $stable(code_q));
  // R3: only table codes are ever held
  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    code_q <= LAST_CODE);
endmodule

// File: rtl/fcd_ratio_lut.sv
module fcd_ratio_lut
  import fcd_pkg::*;
#(
  parameter int HALF_W = $clog2(MAX_RATIO / 2)
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [HALF_W-1:0] half_m1_o
);
  logic [7:0] ratio;

  always_comb begin
    ratio     = ratio_of(code_i);
    half_m1_o = HALF_W'((ratio >> 1) - 8'd1);
  end
endmodule

// File: rtl/fcd_toggle_gen.sv
module fcd_toggle_gen #(
  parameter int HALF_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [HALF_W-1:0] half_m1_i,
  output logic              clk_o
);
  logic              act_q, act_d;
  logic              out_q, out_d;
  logic [HALF_W-1:0] cnt_q, cnt_d;
  logic [HALF_W-1:0] hm1_q, hm1_d;
  logic              wrap;

  assign wrap = (cnt_q == hm1_q);

  always_comb begin
    act_d = act_q;
    out_d = out_q;
    cnt_d = cnt_q;
    hm1_d = hm1_q;
    if (!run_i) begin
      act_d = 1'b0;
      out_d = 1'b0;
      cnt_d = '0;
    end else if (!act_q) begin
      act_d = 1'b1;
      cnt_d = '0;
      hm1_d = half_m1_i;
    end else if (wrap) begin
      cnt_d = '0;
      out_d = ~out_q;
      if (out_q) hm1_d = half_m1_i;  // load only as the output falls
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      out_q <= 1'b0;
      cnt_q <= '0;
      hm1_q <= '0;
    end else begin
      act_q <= act_d;
      out_q <= out_d;
      cnt_q <= cnt_d;
      hm1_q <= hm1_d;
    end
  end

  assign clk_o = out_q;

  // R4: output forced low once run is clear
  a_r4_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !out_q);
  // R6: the running half-period never changes during a high phase
  a_r6_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    act_q && out_q |-> $stable(hm1_q));
  // R3: the phase counter stays inside the loaded half-period
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> cnt_q <= hm1_q);
endmodule

// File: rtl/flash_clk_divider.sv
module flash_clk_divider
  import fcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             clk_out,
  output logic             irq_en
);
  localparam int HALF_W = $clog2(MAX_RATIO / 2);

  logic              srst_n;
  logic              run;
  logic [CODE_W-1:0] code;
  logic [HALF_W-1:0] half_m1;

  fcd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(srst_n)
  );

  fcd_ctrl_reg u_reg (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_data(wr_data),
    .run_o(run), .code_o(code), .irq_o(irq_en), .rd_data_o(rd_data)
  );

  fcd_ratio_lut #(.HALF_W(HALF_W)) u_lut (
    .code_i(code), .half_m1_o(half_m1)
  );

  fcd_toggle_gen #(.HALF_W(HALF_W)) u_gen (
    .clk(clk), .rst_n(srst_n), .run_i(run), .half_m1_i(half_m1),
    .clk_o(clk_out)
  );
endmodule

// File: tb/test_flash_clk_divider.sv
module test_flash_clk_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       clk_out;
  logic       irq_en;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  flash_clk_divider i_flash_clk_divider (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_out(clk_out), .irq_en(irq_en)
  );

  function automatic int exp_ratio(input int c);
    int t[14] = '{4, 6, 8, 10, 12, 16, 18, 20, 24, 32, 40, 50, 64, 128};
    return t[c];
  endfunction

  function automatic logic [7:0] word(input logic [3:0] c, input logic run, input logic irq);
    return {1'b0, irq, 1'b0, c, run};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // counts falling reference edges until the output is seen high
  task automatic wait_rise(output int n);
    n = 0;
    while (!clk_out && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic phase_len(input logic lvl, output int n);
    n = 0;
    while (clk_out == lvl && n < 400) begin n++; @(negedge clk); end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int n, h, l;
    logic [3:0] cur;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h12);
    chk("R1 clk_out", clk_out, 0);
    chk("R1 irq_en", irq_en, 0);
    cur = 4'd9;

    // R8 interrupt enable follows bit 6
    do_wr(word(cur, 1'b0, 1'b1));
    chk("R8 irq_en set", irq_en, 1);
    chk("R2 readback irq", rd_data, word(cur, 1'b0, 1'b1));
    do_wr(word(cur, 1'b0, 1'b0));
    chk("R8 irq_en clear", irq_en, 0);

    // R7 directed reserved code while stopped
    do_wr(word(4'd14, 1'b0, 1'b0));
    chk("R7 code kept 14", rd_data, word(cur, 1'b0, 1'b0));

    // random codes: stop, start, latency and phase lengths
    for (int i = 0; i < 14; i++) begin
      logic [3:0] c;
      logic ir;
      c  = 4'($urandom % 16);
      ir = 1'($urandom % 2);
      if (i == 0) c = 4'd15;
      if (i == 1) c = 4'd0;
      if (i == 2) c = 4'd13;
      do_wr(word(cur, 1'b0, 1'b0));
      do_wr(word(c, 1'b1, ir));
      if (c <= 4'd13) cur = c;
      chk("R2/R7 readback", rd_data, word(cur, 1'b1, ir));
      chk("R8 irq_en", irq_en, ir);
      wait_rise(n);
      chk("R5 start latency", n, exp_ratio(cur) / 2 + 1);
      phase_len(1'b1, h);
      phase_len(1'b0, l);
      chk("R3 high phase", h, exp_ratio(cur) / 2);
      chk("R3 low phase", l, exp_ratio(cur) / 2);
    end

    // R6 code change during a high phase
    do_wr(word(cur, 1'b0, 1'b0));
    do_wr(word(4'd5, 1'b1, 1'b0));
    wait_rise(n);
    h = 1;
    wr_en = 1'b1; wr_data = word(4'd0, 1'b1, 1'b0);
    @(negedge clk); wr_en = 1'b0;
    while (clk_out && h < 400) begin h++; @(negedge clk); end
    phase_len(1'b0, l);
    chk("R6 high kept old", h, 8);
    chk("R6 low uses new", l, 2);
    phase_len(1'b1, h);
    chk("R6 next high new", h, 2);
    cur = 4'd0;

    // R7 reserved code while running keeps ratio
    do_wr(word(4'd15, 1'b1, 1'b0));
    chk("R7 readback running", rd_data, word(cur, 1'b1, 1'b0));
    wait_rise(n);
    phase_len(1'b1, h);
    phase_len(1'b0, l);
    chk("R7 ratio kept high", h, 2);
    chk("R7 ratio kept low", l, 2);

    // R4 gating during a high phase of the slowest ratio
    do_wr(word(4'd13, 1'b1, 1'b0));
    wait_rise(n);
    do_wr(word(4'd13, 1'b0, 1'b0));
    @(negedge clk);
    chk("R4 low after stop", clk_out, 0);
    h = 0;
    repeat (300) begin @(negedge clk); if (clk_out) h++; end
    chk("R4 stays low", h, 0);
    chk("R4 readback stopped", rd_data, word(4'd13, 1'b0, 1'b0));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule